// File: doc/BRIEF.md
# Inter-Processor Event Flag Bank

This block holds a bank of 32 event flags that let one processor signal another. The sending processor raises flags by writing ones into a set register. It can withdraw flags it raised by writing ones into a clear register. The receiving processor retires a flag by writing a one into an acknowledge register. Both sides read the live flag word through a read-only view. The receiving side can also read it through a second, identical status view.

Each processor reaches the block over its own simple bus. A bus access takes one cycle. Read data is combinational in the cycle of the read, and a write takes effect at the next rising clock edge. Flags 1 to 4 (bit positions 0 to 3) drive four interrupt request lines toward the receiving core. The interrupt controller, any message memory and any clock-domain crossing are outside this block; both buses share one clock.

Top module: `ipc_flag_regs`

## Requirements
- R1: While `rst_n` is low, every flag is held at 0 and every `irq_o` bit is 0 (synchronous reset).
- R2: A sender write to offset 0x00 (the set register) sets each flag whose bit is 1 in the write data, at the next rising edge. Bit k of the data word is flag k+1. Data bits that are 0 leave their flags unchanged.
- R3: A flag that is 1 stays 1 on every edge where no clear or acknowledge strikes its bit.
- R4: A sender write to offset 0x04 (the clear register) zeroes each flag whose data bit is 1. A receiver write to offset 0x0C (the acknowledge register) does the same.
- R5: If a set and a clear or acknowledge strike the same bit in the same cycle, the flag ends at 0.
- R6: A read of offset 0x00, 0x04 or 0x0C returns zero on either bus.
- R7: Offset 0x08 returns the flag word on both buses. Offset 0x10 returns the same word on the receiver bus and zero on the sender bus. Writes to 0x08 or 0x10 change nothing.
- R8: A receiver write to 0x00 or 0x04 changes nothing. A sender write to 0x0C changes nothing.
- R9: `irq_o[n-1]` equals flag n for n = 1 to 4. After an acknowledge of that flag, the line is low in the next cycle.
- R10: An access whose address bits [1:0] are not 00 writes nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_sel | input | 1 | Sender bus access strobe |
| tx_wr | input | 1 | Sender bus write (1) or read (0) |
| tx_addr | input | 5 | Sender bus byte offset |
| tx_wdata | input | 32 | Sender bus write data |
| tx_rdata | output | 32 | Sender bus read data, same cycle |
| rx_sel | input | 1 | Receiver bus access strobe |
| rx_wr | input | 1 | Receiver bus write (1) or read (0) |
| rx_addr | input | 5 | Receiver bus byte offset |
| rx_wdata | input | 32 | Receiver bus write data |
| rx_rdata | output | 32 | Receiver bus read data, same cycle |
| irq_o | output | 4 | Interrupt requests, one per flag 1 to 4 |

## Verification
The bench drives a set from the sender and an acknowledge from the receiver onto one bit in the same cycle. A design that let the set win would leave that flag stuck at 1. It also aims each bus at the registers the other bus owns, and at misaligned offsets. A decoder that ignored ownership or the low address bits would then change or clear flags. It checks that the write-only registers read as zero even while flags are up, since a decoder that aliased them onto the flag word would leak state. Finally, it samples the interrupt lines one cycle after an acknowledge, to catch a request that is registered too late or never released.

// File: rtl/ipc_flag_pkg.sv
package ipc_flag_pkg;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SET,
        SEL_CLR,
        SEL_FLAG,
        SEL_ACK,
        SEL_STAT
    } reg_sel_e;

    localparam logic [31:0] OFS_SET  = 32'h00;
    localparam logic [31:0] OFS_CLR  = 32'h04;
    localparam logic [31:0] OFS_FLAG = 32'h08;
    localparam logic [31:0] OFS_ACK  = 32'h0C;
    localparam logic [31:0] OFS_STAT = 32'h10;

    function automatic reg_sel_e decode_sel(input logic [31:0] a);
        reg_sel_e r;
        r = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            case (a)
                OFS_SET:  r = SEL_SET;
                OFS_CLR:  r = SEL_CLR;
                OFS_FLAG: r = SEL_FLAG;
                OFS_ACK:  r = SEL_ACK;
                OFS_STAT: r = SEL_STAT;
                default:  r = SEL_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/ipc_side_decode.sv
module ipc_side_decode
    import ipc_flag_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 32,
    parameter bit IS_SENDER = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] flags_i,
    output logic [DATA_W-1:0] set_o,
    output logic [DATA_W-1:0] clr_o,
    output logic [DATA_W-1:0] ack_o,
    output logic [DATA_W-1:0] rdata_o
);

    reg_sel_e sel_d;
    logic     wr_en_d;
    logic     rd_en_d;

    always_comb begin
        sel_d   = decode_sel(32'(addr_i));
        wr_en_d = sel_i & wr_i;
        rd_en_d = sel_i & ~wr_i;
    end

    generate
        if (IS_SENDER) begin : g_tx
            always_comb begin
                set_o   = (wr_en_d && sel_d == SEL_SET) ? wdata_i : '0;
                clr_o   = (wr_en_d && sel_d == SEL_CLR) ? wdata_i : '0;
                ack_o   = '0;
                rdata_o = (rd_en_d && sel_d == SEL_FLAG) ? flags_i : '0;
            end
        end else begin : g_rx
            always_comb begin
                set_o   = '0;
                clr_o   = '0;
                ack_o   = (wr_en_d && sel_d == SEL_ACK) ? wdata_i : '0;
                rdata_o = (rd_en_d && (sel_d == SEL_FLAG || sel_d == SEL_STAT))
                          ? flags_i : '0;
            end
        end
    endgenerate

    // Write-only registers never expose flag state
    assert_wo_read_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_d && (sel_d == SEL_SET || sel_d == SEL_CLR || sel_d == SEL_ACK))
        |-> (rdata_o == '0));

    // Misaligned offsets decode to nothing
    assert_misalign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && addr_i[1:0] != 2'b00)
        |-> ((set_o | clr_o | ack_o | rdata_o) == '0));

endmodule

// File: rtl/ipc_flag_store.sv
module ipc_flag_store #(
    parameter int NUM_FLAGS = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] set_i,
    input  logic [NUM_FLAGS-1:0] clr_i,
    input  logic [NUM_FLAGS-1:0] ack_i,
    output logic [NUM_FLAGS-1:0] flags_o
);

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } store_t;

    store_t st_d, st_q;
    logic [NUM_FLAGS-1:0] kill_d;

    always_comb begin
        st_d       = st_q;
        kill_d     = clr_i | ack_i;
        st_d.flags = (st_q.flags | set_i) & ~kill_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;

    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (st_q.flags == '0));

    assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~(clr_i | ack_i)))
        |=> ((st_q.flags & $past(set_i & ~(clr_i | ack_i)))
             == $past(set_i & ~(clr_i | ack_i))));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.flags & $past(st_q.flags & ~(clr_i | ack_i)))
                  == $past(st_q.flags & ~(clr_i | ack_i))));

    // Clear or acknowledge always ends a flag at 0 (R4), even against a set (R5)
    assert_kill_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i | ack_i)) |=> ((st_q.flags & $past(clr_i | ack_i)) == '0));

endmodule

// File: rtl/ipc_irq_out.sv
module ipc_irq_out #(
    parameter int NUM_IRQ = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] flags_lo_i,
    input  logic [NUM_IRQ-1:0] ack_lo_i,
    output logic [NUM_IRQ-1:0] irq_o
);

    generate
        for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
            assign irq_o[k] = flags_lo_i[k];
        end
    endgenerate

    assert_irq_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack_lo_i) |=> ((irq_o & $past(ack_lo_i)) == '0));

endmodule

// File: rtl/ipc_flag_regs.sv
module ipc_flag_regs #(
    parameter int NUM_FLAGS = 32,
    parameter int NUM_IRQ   = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_sel,
    input  logic                 tx_wr,
    input  logic [ADDR_W-1:0]    tx_addr,
    input  logic [NUM_FLAGS-1:0] tx_wdata,
    output logic [NUM_FLAGS-1:0] tx_rdata,
    input  logic                 rx_sel,
    input  logic                 rx_wr,
    input  logic [ADDR_W-1:0]    rx_addr,
    input  logic [NUM_FLAGS-1:0] rx_wdata,
    output logic [NUM_FLAGS-1:0] rx_rdata,
    output logic [NUM_IRQ-1:0]   irq_o
);

    localparam int DATA_W = NUM_FLAGS;

    logic [DATA_W-1:0] flags_q;
    logic [DATA_W-1:0] tx_set, tx_clr, tx_ack;
    logic [DATA_W-1:0] rx_set, rx_clr, rx_ack;
    logic [DATA_W-1:0] set_all, clr_all, ack_all;

    ipc_side_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_SENDER(1'b1)) i_tx_dec (
        .clk(clk), .rst_n(rst_n),
        .sel_i(tx_sel), .wr_i(tx_wr), .addr_i(tx_addr), .wdata_i(tx_wdata),
        .flags_i(flags_q),
        .set_o(tx_set), .clr_o(tx_clr), .ack_o(tx_ack), .rdata_o(tx_rdata)
    );

    ipc_side_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IS_SENDER(1'b0)) i_rx_dec (
        .clk(clk), .rst_n(rst_n),
        .sel_i(rx_sel), .wr_i(rx_wr), .addr_i(rx_addr), .wdata_i(rx_wdata),
        .flags_i(flags_q),
        .set_o(rx_set), .clr_o(rx_clr), .ack_o(rx_ack), .rdata_o(rx_rdata)
    );

    always_comb begin
        set_all = tx_set | rx_set;
        clr_all = tx_clr | rx_clr;
        ack_all = tx_ack | rx_ack;
    end

    ipc_flag_store #(.NUM_FLAGS(NUM_FLAGS)) i_store (
        .clk(clk), .rst_n(rst_n),
        .set_i(set_all), .clr_i(clr_all), .ack_i(ack_all),
        .flags_o(flags_q)
    );

    ipc_irq_out #(.NUM_IRQ(NUM_IRQ)) i_irq (
        .clk(clk), .rst_n(rst_n),
        .flags_lo_i(flags_q[NUM_IRQ-1:0]),
        .ack_lo_i(ack_all[NUM_IRQ-1:0]),
        .irq_o(irq_o)
    );

    // Bus ownership: the receiver side never raises or withdraws flags
    assert_rx_no_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sel && rx_wr && !(tx_sel && tx_wr)) |=> ((flags_q & ~$past(flags_q)) == '0));

    // The sender side never acknowledges
    assert_tx_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_sel && tx_wr && !(rx_sel && rx_wr) && tx_addr == ADDR_W'(32'h0C))
        |=> (flags_q == $past(flags_q)));

    // Flag and status views agree on the receiver side
    assert_views_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sel && !rx_wr && (rx_addr == ADDR_W'(32'h08) || rx_addr == ADDR_W'(32'h10)))
        |-> (rx_rdata == flags_q));

endmodule

// File: tb/test_ipc_flag_regs.sv
module test_ipc_flag_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 14;

    typedef struct packed {
        logic        te;
        logic [4:0]  ta;
        logic [31:0] td;
        logic        re;
        logic [4:0]  ra;
        logic [31:0] rd;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h00, 32'h0000_0005, 1'b0, 5'h00, 32'h0,          32'h0000_0005}, // R2
        '{1'b1, 5'h00, 32'h8000_0000, 1'b0, 5'h00, 32'h0,          32'h8000_0005}, // R2
        '{1'b1, 5'h00, 32'h0000_0000, 1'b0, 5'h00, 32'h0,          32'h8000_0005}, // R2 zeros
        '{1'b1, 5'h04, 32'h0000_0001, 1'b0, 5'h00, 32'h0,          32'h8000_0004}, // R4 clear
        '{1'b0, 5'h00, 32'h0,         1'b1, 5'h0C, 32'h8000_0000,  32'h0000_0004}, // R4 ack
        '{1'b1, 5'h00, 32'h0000_00F0, 1'b1, 5'h0C, 32'h0000_0010,  32'h0000_00E4}, // R5
        '{1'b1, 5'h08, 32'hFFFF_FFFF, 1'b0, 5'h00, 32'h0,          32'h0000_00E4}, // R7
        '{1'b0, 5'h00, 32'h0,         1'b1, 5'h10, 32'hFFFF_FFFF,  32'h0000_00E4}, // R7
        '{1'b0, 5'h00, 32'h0,         1'b1, 5'h00, 32'h0000_0001,  32'h0000_00E4}, // R8
        '{1'b0, 5'h00, 32'h0,         1'b1, 5'h04, 32'h0000_00E4,  32'h0000_00E4}, // R8
        '{1'b1, 5'h0C, 32'h0000_00E4, 1'b0, 5'h00, 32'h0,          32'h0000_00E4}, // R8
        '{1'b1, 5'h01, 32'h0000_0009, 1'b0, 5'h00, 32'h0,          32'h0000_00E4}, // R10
        '{1'b1, 5'h00, 32'h0000_000F, 1'b0, 5'h00, 32'h0,          32'h0000_00EF}, // R2
        '{1'b1, 5'h04, 32'hFFFF_FFFF, 1'b0, 5'h00, 32'h0,          32'h0000_0000}  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_sel = 1'b0, tx_wr = 1'b0, rx_sel = 1'b0, rx_wr = 1'b0;
    logic [4:0]  tx_addr = '0, rx_addr = '0;
    logic [31:0] tx_wdata = '0, rx_wdata = '0;
    logic [31:0] tx_rdata, rx_rdata;
    logic [3:0]  irq_o;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipc_flag_regs i_ipc_flag_regs (
        .clk(clk), .rst_n(rst_n),
        .tx_sel(tx_sel), .tx_wr(tx_wr), .tx_addr(tx_addr), .tx_wdata(tx_wdata), .tx_rdata(tx_rdata),
        .rx_sel(rx_sel), .rx_wr(rx_wr), .rx_addr(rx_addr), .rx_wdata(rx_wdata), .rx_rdata(rx_rdata),
        .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic te, input logic [4:0] ta, input logic [31:0] td,
                       input logic re, input logic [4:0] ra, input logic [31:0] rd);
        @(negedge clk);
        tx_sel = te; tx_wr = te; tx_addr = ta; tx_wdata = td;
        rx_sel = re; rx_wr = re; rx_addr = ra; rx_wdata = rd;
        @(posedge clk);
        #1;
        tx_sel = 1'b0; tx_wr = 1'b0; rx_sel = 1'b0; rx_wr = 1'b0;
    endtask

    task automatic rd_tx(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        tx_sel = 1'b1; tx_wr = 1'b0; tx_addr = a;
        #2;
        d = tx_rdata;
        tx_sel = 1'b0;
    endtask

    task automatic rd_rx(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rx_sel = 1'b1; rx_wr = 1'b0; rx_addr = a;
        #2;
        d = rx_rdata;
        rx_sel = 1'b0;
    endtask

    task automatic finish_run;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset flags", {28'h0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_tx(5'h08, d);
        check("R1 flag word after reset", d, 32'h0);

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].te, VECS[i].ta, VECS[i].td, VECS[i].re, VECS[i].ra, VECS[i].rd);
            rd_tx(5'h08, d);
            check($sformatf("vector %0d flag view R2/R4/R5/R8/R10", i), d, VECS[i].exp);
            rd_rx(5'h10, d);
            check($sformatf("vector %0d status view R7", i), d, VECS[i].exp);
            check($sformatf("vector %0d irq R9", i), {28'h0, irq_o}, {28'h0, VECS[i].exp[3:0]});
        end

        // R6: write-only registers read zero while flags are up
        cyc(1'b1, 5'h00, 32'hA5A5_0003, 1'b0, 5'h00, 32'h0);
        rd_tx(5'h00, d); check("R6 tx read set", d, 32'h0);
        rd_tx(5'h04, d); check("R6 tx read clear", d, 32'h0);
        rd_rx(5'h0C, d); check("R6 rx read ack", d, 32'h0);
        rd_rx(5'h00, d); check("R6 rx read set", d, 32'h0);
        rd_tx(5'h10, d); check("R7 tx read status", d, 32'h0);
        rd_rx(5'h08, d); check("R7 rx read flag", d, 32'hA5A5_0003);
        rd_tx(5'h09, d); check("R10 misaligned read", d, 32'h0);

        // R3: flags hold across idle cycles
        repeat (5) @(posedge clk);
        rd_tx(5'h08, d); check("R3 hold", d, 32'hA5A5_0003);

        // R9: irq timing around acknowledge
        cyc(1'b1, 5'h00, 32'h0000_0004, 1'b0, 5'h00, 32'h0);
        check("R9 irq after set", {28'h0, irq_o}, 32'h7);
        cyc(1'b0, 5'h00, 32'h0, 1'b1, 5'h0C, 32'h0000_0002);
        check("R9 irq drops after ack", {28'h0, irq_o}, 32'h5);

        // R5: same-bit set and acknowledge on an already-set flag
        cyc(1'b1, 5'h00, 32'h0000_0001, 1'b1, 5'h0C, 32'h0000_0001);
        check("R5 ack beats set", {28'h0, irq_o}, 32'h4);

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R1 irq cleared by reset", {28'h0, irq_o}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_tx(5'h08, d); check("R1 flags cleared by reset", d, 32'h0);

        finish_run();
    end

endmodule